// File: doc/BRIEF.md
# Pencil-Over-Colour Threshold Blender

This stage merges two pixel streams that arrive in lockstep: an 8-bit grey pencil-sketch value and a 24-bit colour pixel. For every pair it derives a see-through weight from the pencil value and mixes each colour byte with the pencil grey. The output is one tinted 24-bit pixel. Dark pencil strokes stay opaque. Lighter pencil areas let the colour show through by an amount that a linear ramp sets, and three threshold registers shape that ramp.

The weight curve is flat at zero below a cut-off level. Above it, the curve rises or falls linearly from an offset level toward an end level as the pencil value approaches white. The slope of that ramp is held as a signed fixed-point constant with 8 fraction bits. It is recomputed from the threshold registers, so the per-pixel path needs only a multiply, a shift and an add. All three streams use valid/ready handshakes. With the sink ready, the stage accepts and emits one pixel per clock.

Top module: `pencil_tint_blend`

## Requirements
- R1: During and right after reset, `outValid` is low. The cut-off, offset and end levels reset to 100, 100 and 150, and pixels sent without any configuration load are blended with these values.
- R2: A pencil value strictly below the cut-off level gives weight 0. Each of the three output bytes then equals the pencil value, whatever the colour.
- R3: When the pencil value is at or above the cut-off, the weight is `offset + ((pen - cutoff) * S >>> 8)`. Here `S = trunc((end - offset) * 256 / (255 - cutoff))`, the division truncates toward zero, and `>>>` is an arithmetic shift that rounds toward minus infinity.
- R4: Before use, the weight is clamped to the range 0..255.
- R5: Each colour byte c is blended as `(c * w + pen * (256 - w)) >> 8`, and the result saturates at 255. Blue sits in bits 7:0, green in 15:8 and red in 23:16, on both input and output. Each byte is blended on its own and written back to the same position.
- R6: With a cut-off of 255, S is 0, so a pencil value of 255 is blended with weight equal to the offset level.
- R7: A high `cfgLoad` captures all three threshold inputs on the clock edge. A pixel accepted two or more cycles after that edge uses the new values.
- R8: With `outReady` held high, a pixel accepted in cycle n is presented on `outValid`/`outData` in cycle n+3.
- R9: A pixel is consumed only when both inputs are valid. Pencil and colour always transfer in the same cycle, and a lone valid input is neither consumed nor produces output.
- R10: While `outValid` is high and `outReady` is low, `outValid` and `outData` hold steady. Once three pixels are stalled inside, input ready drops, and no pixel is lost or reordered.
- R11: With `outReady` high and both inputs valid, both input ready signals are high, so back-to-back pixels flow with no wait cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| cfgLoad | input | 1 | Capture strobe for the three threshold inputs |
| cutoffIn | input | 8 | Cut-off level below which pencil is opaque |
| offsetIn | input | 8 | Weight at the cut-off level |
| endIn | input | 8 | Ramp end level reached at pencil value 255 |
| penValid | input | 1 | Pencil pixel valid |
| penReady | output | 1 | Pencil pixel accepted when high with penValid |
| penData | input | 8 | Pencil grey value, 0 black, 255 white |
| colValid | input | 1 | Colour pixel valid |
| colReady | output | 1 | Colour pixel accepted when high with colValid |
| colData | input | 24 | Colour pixel, B in 7:0, G in 15:8, R in 23:16 |
| outValid | output | 1 | Blended pixel valid |
| outReady | input | 1 | Sink ready |
| outData | output | 24 | Blended pixel, same byte layout as colData |

## Verification
A pixel's result is due three cycles after the cycle in which both inputs hand it over. The bench records the cycle number at each acceptance and compares it with the cycle in which the matching output transfers. Threshold writes take two cycles to settle into the slope register, so the bench drains the pipeline and waits out those two cycles before sending pixels under new thresholds. Inputs are driven on the falling edge. Handshakes and outputs are sampled one and two time units later, before the next rising edge acts on them.

// File: rtl/pt_pkg.sv
package pt_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic advance;  // every stage moves one step
    logic fill;     // a fresh pixel pair enters stage one
  } pt_strobe_t;

  localparam int PT_STAGES = 3;

endpackage

// File: rtl/pt_ctrl.sv
module pt_ctrl
  import pt_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int FRAC_W   = 8,
  parameter int TH_RST   = 100,
  parameter int LOW_RST  = 100,
  parameter int HIGH_RST = 150,
  localparam int SLOPE_W = PIX_W + FRAC_W + 2,
  localparam int MAXV    = (1 << PIX_W) - 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgLoad,
  input  logic [PIX_W-1:0]          cutoffIn,
  input  logic [PIX_W-1:0]          offsetIn,
  input  logic [PIX_W-1:0]          endIn,
  input  logic                      penValid,
  input  logic                      colValid,
  input  logic                      outReady,
  output logic                      penReady,
  output logic                      colReady,
  output logic                      outValid,
  output pt_strobe_t                stb,
  output logic [PIX_W-1:0]          thBase,
  output logic [PIX_W-1:0]          thLow,
  output logic signed [SLOPE_W-1:0] slope
);

  localparam int SLOPE_RST = (TH_RST >= MAXV) ? 0 :
                             ((HIGH_RST - LOW_RST) * (1 << FRAC_W)) / (MAXV - TH_RST);

  logic [PIX_W-1:0]          thHigh;
  logic [PT_STAGES-1:0]      vPipe;
  logic                      advance;
  logic                      pairValid;
  logic signed [PIX_W:0]     spanDiff;
  logic signed [SLOPE_W-1:0] numer;
  logic signed [SLOPE_W-1:0] denom;
  logic signed [SLOPE_W-1:0] slopeNext;

  // Handshake: the whole pipe moves unless the last stage is stuck
  assign advance   = !vPipe[PT_STAGES-1] || outReady;
  assign pairValid = penValid && colValid;
  assign penReady  = advance && colValid;
  assign colReady  = advance && penValid;
  assign outValid  = vPipe[PT_STAGES-1];

  assign stb.advance = advance;
  assign stb.fill    = advance && pairValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vPipe <= '0;
    end else if (advance) begin
      vPipe <= {vPipe[PT_STAGES-2:0], pairValid};
    end
  end

  // Threshold registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      thBase <= PIX_W'(TH_RST);
      thLow  <= PIX_W'(LOW_RST);
      thHigh <= PIX_W'(HIGH_RST);
    end else if (cfgLoad) begin
      thBase <= cutoffIn;
      thLow  <= offsetIn;
      thHigh <= endIn;
    end
  end

  // Slope constant in signed fixed point, refreshed from the registers
  always_comb begin
    spanDiff = $signed({1'b0, thHigh}) - $signed({1'b0, thLow});
    numer    = {{(SLOPE_W-PIX_W-1){spanDiff[PIX_W]}}, spanDiff} <<< FRAC_W;
    denom    = $signed(SLOPE_W'(MAXV - int'(thBase)));
    if (thBase == PIX_W'(MAXV)) begin
      slopeNext = '0;
    end else begin
      slopeNext = numer / denom;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slope <= SLOPE_W'(SLOPE_RST);
    end else begin
      slope <= slopeNext;
    end
  end

endmodule

// File: rtl/pt_datapath.sv
module pt_datapath
  import pt_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int CHANNELS = 3,
  parameter int FRAC_W   = 8,
  localparam int SLOPE_W = PIX_W + FRAC_W + 2,
  localparam int PROD_W  = PIX_W + 1 + SLOPE_W,
  localparam int BL_W    = 2 * PIX_W + 2,
  localparam int COL_W   = PIX_W * CHANNELS,
  localparam int MAXV    = (1 << PIX_W) - 1,
  localparam int ONE     = 1 << PIX_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  pt_strobe_t                stb,
  input  logic [PIX_W-1:0]          penIn,
  input  logic [COL_W-1:0]          colIn,
  input  logic [PIX_W-1:0]          thBase,
  input  logic [PIX_W-1:0]          thLow,
  input  logic signed [SLOPE_W-1:0] slope,
  output logic [COL_W-1:0]          pixOut
);

  // Stage 1: distance from the cut-off
  logic [PIX_W-1:0]      s1Pen;
  logic [COL_W-1:0]      s1Col;
  logic signed [PIX_W:0] s1Diff;
  logic                  s1Below;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Pen   <= '0;
      s1Col   <= '0;
      s1Diff  <= '0;
      s1Below <= 1'b1;
    end else if (stb.fill) begin
      s1Pen   <= penIn;
      s1Col   <= colIn;
      s1Diff  <= $signed({1'b0, penIn}) - $signed({1'b0, thBase});
      s1Below <= penIn < thBase;
    end
  end

  // Stage 2: weight from the ramp, clamped
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] yRaw;
  logic [PIX_W-1:0]         yNext;
  logic [PIX_W-1:0]         s2Pen;
  logic [COL_W-1:0]         s2Col;
  logic [PIX_W-1:0]         s2Y;

  always_comb begin
    prod = PROD_W'(s1Diff) * PROD_W'(slope);
    yRaw = (prod >>> FRAC_W) + $signed(PROD_W'(thLow));
    if (s1Below || yRaw < 0) begin
      yNext = '0;
    end else if (yRaw > $signed(PROD_W'(MAXV))) begin
      yNext = PIX_W'(MAXV);
    end else begin
      yNext = yRaw[PIX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s2Pen <= '0;
      s2Col <= '0;
      s2Y   <= '0;
    end else if (stb.advance) begin
      s2Pen <= s1Pen;
      s2Col <= s1Col;
      s2Y   <= yNext;
    end
  end

  // Stage 3: per-channel blend, repacked
  logic [PIX_W-1:0] chanMix [CHANNELS];
  logic [COL_W-1:0] mixPacked;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    logic [PIX_W-1:0] chanIn;
    logic [BL_W-1:0]  mixSum;
    logic [BL_W-1:0]  mixShift;

    assign chanIn   = s2Col[ch*PIX_W +: PIX_W];
    assign mixSum   = BL_W'(chanIn) * BL_W'(s2Y)
                    + BL_W'(s2Pen) * (BL_W'(ONE) - BL_W'(s2Y));
    assign mixShift = mixSum >> PIX_W;
    assign chanMix[ch] = (mixShift > BL_W'(MAXV)) ? PIX_W'(MAXV)
                                                  : mixShift[PIX_W-1:0];
    assign mixPacked[ch*PIX_W +: PIX_W] = chanMix[ch];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixOut <= '0;
    end else if (stb.advance) begin
      pixOut <= mixPacked;
    end
  end

endmodule

// File: rtl/pencil_tint_blend.sv
module pencil_tint_blend
  import pt_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int CHANNELS = 3,
  parameter int FRAC_W   = 8,
  parameter int TH_RST   = 100,
  parameter int LOW_RST  = 100,
  parameter int HIGH_RST = 150,
  localparam int SLOPE_W = PIX_W + FRAC_W + 2,
  localparam int COL_W   = PIX_W * CHANNELS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic [PIX_W-1:0] cutoffIn,
  input  logic [PIX_W-1:0] offsetIn,
  input  logic [PIX_W-1:0] endIn,
  input  logic             penValid,
  output logic             penReady,
  input  logic [PIX_W-1:0] penData,
  input  logic             colValid,
  output logic             colReady,
  input  logic [COL_W-1:0] colData,
  output logic             outValid,
  input  logic             outReady,
  output logic [COL_W-1:0] outData
);

  pt_strobe_t                stb;
  logic [PIX_W-1:0]          thBaseQ;
  logic [PIX_W-1:0]          thLowQ;
  logic signed [SLOPE_W-1:0] slopeQ;

  pt_ctrl #(
    .PIX_W(PIX_W), .FRAC_W(FRAC_W),
    .TH_RST(TH_RST), .LOW_RST(LOW_RST), .HIGH_RST(HIGH_RST)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad),
    .cutoffIn(cutoffIn), .offsetIn(offsetIn), .endIn(endIn),
    .penValid(penValid), .colValid(colValid), .outReady(outReady),
    .penReady(penReady), .colReady(colReady), .outValid(outValid),
    .stb(stb), .thBase(thBaseQ), .thLow(thLowQ), .slope(slopeQ)
  );

  pt_datapath #(
    .PIX_W(PIX_W), .CHANNELS(CHANNELS), .FRAC_W(FRAC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .penIn(penData), .colIn(colData),
    .thBase(thBaseQ), .thLow(thLowQ), .slope(slopeQ),
    .pixOut(outData)
  );

endmodule

// File: rtl/pt_blend_checker.sv
module pt_blend_checker #(
  parameter int PIX_W    = 8,
  parameter int CHANNELS = 3,
  parameter int SLOPE_W  = 18,
  localparam int COL_W   = PIX_W * CHANNELS,
  localparam int MAXV    = (1 << PIX_W) - 1
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      penValid,
  input logic                      penReady,
  input logic                      colValid,
  input logic                      colReady,
  input logic                      outValid,
  input logic                      outReady,
  input logic [COL_W-1:0]          outData,
  input logic [PIX_W-1:0]          thBase,
  input logic signed [SLOPE_W-1:0] slope
);

  logic fireIn;
  logic rstSeen;
  assign fireIn = penValid && penReady && colValid && colReady;

  always_ff @(posedge clk) begin
    if (!rstN) rstSeen <= 1'b1;
  end

  // R1: output idle while held in reset
  always_ff @(posedge clk) begin
    if (rstSeen === 1'b1 && !rstN) begin
      p_reset_idle_r1: assert (!outValid);
    end
  end

  // R6: slope register zero once cut-off sits at full scale
  p_slope_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(thBase) == PIX_W'(MAXV)) |-> (slope == '0));

  // R8: three-cycle latency when the sink keeps up
  p_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(fireIn, 3) && $past(outReady, 2) && $past(outReady, 1)) |-> outValid);

  // R9: both inputs transfer together
  p_pair_pen_r9: assert property (@(posedge clk) disable iff (!rstN)
    (penValid && penReady) |-> (colValid && colReady));
  p_pair_col_r9: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && colReady) |-> (penValid && penReady));

  // R10: stalled output holds
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R11: full rate while the sink is ready
  p_full_rate_r11: assert property (@(posedge clk) disable iff (!rstN)
    (outReady && penValid && colValid) |-> (penReady && colReady));

endmodule

bind pencil_tint_blend pt_blend_checker #(
  .PIX_W(PIX_W), .CHANNELS(CHANNELS), .SLOPE_W(SLOPE_W)
) u_chk (
  .clk(clk), .rstN(rstN),
  .penValid(penValid), .penReady(penReady),
  .colValid(colValid), .colReady(colReady),
  .outValid(outValid), .outReady(outReady), .outData(outData),
  .thBase(thBaseQ), .slope(slopeQ)
);

// File: tb/tb_pencil_tint_blend.sv
module tb_pencil_tint_blend;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgLoad = 1'b0;
  logic [7:0]  cutoffIn = '0, offsetIn = '0, endIn = '0;
  logic        penValid = 1'b0, colValid = 1'b0, outReady = 1'b1;
  logic        penReady, colReady, outValid;
  logic [7:0]  penData = '0;
  logic [23:0] colData = '0, outData;

  always #(CLK_PERIOD/2) clk = ~clk;

  pencil_tint_blend dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad),
    .cutoffIn(cutoffIn), .offsetIn(offsetIn), .endIn(endIn),
    .penValid(penValid), .penReady(penReady), .penData(penData),
    .colValid(colValid), .colReady(colReady), .colData(colData),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int cfgTh = 100, cfgLo = 100, cfgHi = 150;
  bit latCheck = 0;
  string curTag = "R1";
  logic [23:0] expQ[$];
  int accQ[$];

  always @(posedge clk) cyc++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Reference blend from the requirements (R3, R4, R5, R6)
  function automatic logic [23:0] model(input int pen, input int col);
    int s, y, v;
    logic [23:0] r;
    s = (cfgTh == 255) ? 0 : ((cfgHi - cfgLo) * 256) / (255 - cfgTh);
    if (pen < cfgTh) y = 0;
    else y = (((pen - cfgTh) * s) >>> 8) + cfgLo;
    if (y < 0) y = 0;
    if (y > 255) y = 255;
    for (int ch = 0; ch < 3; ch++) begin
      v = ((((col >> (8*ch)) & 255) * y) + pen * (256 - y)) >> 8;
      if (v > 255) v = 255;
      r[8*ch +: 8] = v[7:0];
    end
    return r;
  endfunction

  // Output monitor: compares every transfer against the expected queue
  always @(negedge clk) begin
    #2;
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) begin
        check({curTag, " unexpected output"}, {8'h0, outData}, 32'hFFFF_FFFF);
      end else begin
        check(curTag, {8'h0, outData}, {8'h0, expQ.pop_front()});
        if (latCheck) check("R8 latency", cyc - accQ[0], 3);
        void'(accQ.pop_front());
      end
    end
  end

  task automatic sendPix(input logic [7:0] p, input logic [23:0] c, output int waits);
    waits = 0;
    @(negedge clk);
    penData = p; colData = c; penValid = 1'b1; colValid = 1'b1;
    #1;
    while (!(penReady && colReady)) begin
      @(negedge clk); #1; waits++;
    end
    expQ.push_back(model(p, c));
    accQ.push_back(cyc);
    @(posedge clk); #1;
    penValid = 1'b0; colValid = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic loadCfg(input int th, input int lo, input int hi);
    drain();
    @(negedge clk);
    cutoffIn = th[7:0]; offsetIn = lo[7:0]; endIn = hi[7:0]; cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
    cfgTh = th; cfgLo = lo; cfgHi = hi;
    repeat (2) @(negedge clk); // R7: settle window
  endtask

  task automatic testReset();
    int w;
    curTag = "R1";
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 outValid in reset", {31'b0, outValid}, 0);
    rstN = 1'b1;
    @(negedge clk); #1;
    check("R1 outValid after reset", {31'b0, outValid}, 0);
    // Defaults 100/100/150 without any configuration load
    sendPix(8'd150, 24'h20_80_F0, w);
    sendPix(8'd255, 24'h00_FF_10, w);
    sendPix(8'd100, 24'hFF_FF_FF, w);
    drain();
  endtask

  task automatic testBelow();
    int w;
    loadCfg(200, 60, 240);
    curTag = "R2";
    sendPix(8'd0,   24'hFF_FF_FF, w);
    sendPix(8'd199, 24'h00_00_00, w);
    sendPix(8'd77,  24'h12_34_56, w);
    drain();
  endtask

  task automatic testRamp();
    int w;
    loadCfg(50, 20, 240);
    curTag = "R3 R5 rising";
    for (int p = 50; p <= 255; p += 41) sendPix(p[7:0], 24'hC0_40_E0, w);
    loadCfg(0, 230, 10);
    curTag = "R3 R4 falling";
    for (int p = 0; p <= 255; p += 51) sendPix(p[7:0], 24'h01_FE_7F, w);
    loadCfg(254, 250, 255);
    curTag = "R4 R5 clamp top";
    sendPix(8'd255, 24'hFF_00_FF, w);
    sendPix(8'd254, 24'h00_FF_00, w);
    drain();
  endtask

  task automatic testTopCutoff();
    int w;
    loadCfg(255, 40, 200);
    curTag = "R6";
    sendPix(8'd255, 24'hFF_80_00, w);
    sendPix(8'd254, 24'hFF_80_00, w);
    drain();
  endtask

  task automatic testCfgLatency();
    int w;
    loadCfg(10, 0, 255);
    curTag = "R7 R8";
    latCheck = 1;
    sendPix(8'd128, 24'h55_AA_33, w);
    drain();
    latCheck = 0;
  endtask

  task automatic testOneSided();
    int w;
    curTag = "R9";
    @(negedge clk);
    penData = 8'd9; penValid = 1'b1; colValid = 1'b0;
    repeat (4) begin
      @(negedge clk); #1;
      check("R9 pen alone not taken", {31'b0, penReady}, 0);
    end
    penValid = 1'b0; colValid = 1'b1;
    repeat (4) begin
      @(negedge clk); #1;
      check("R9 colour alone not taken", {31'b0, colReady}, 0);
    end
    colValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 no output from lone input", {31'b0, outValid}, 0);
    sendPix(8'd200, 24'h0F_F0_88, w);
    drain();
  endtask

  task automatic testBackpressure();
    int w;
    logic [23:0] held;
    curTag = "R10";
    @(negedge clk); outReady = 1'b0;
    sendPix(8'd10,  24'h11_22_33, w);
    sendPix(8'd180, 24'h44_55_66, w);
    sendPix(8'd240, 24'h77_88_99, w);
    @(negedge clk);
    penData = 8'd255; colData = 24'hAB_CD_EF; penValid = 1'b1; colValid = 1'b1;
    #1;
    held = outData;
    check("R10 input blocked when full", {31'b0, penReady}, 0);
    repeat (4) begin
      @(negedge clk); #1;
      check("R10 valid held", {31'b0, outValid}, 1);
      check("R10 data held", {8'h0, outData}, {8'h0, held});
    end
    penValid = 1'b0; colValid = 1'b0;
    outReady = 1'b1;
    sendPix(8'd255, 24'hAB_CD_EF, w);
    drain();
  endtask

  task automatic testThroughput();
    int w, total;
    curTag = "R11";
    total = 0;
    for (int i = 0; i < 20; i++) begin
      sendPix(8'(i * 13), 24'(i * 24'h0A_0B_0C), w);
      total += w;
    end
    check("R11 wait cycles in burst", total, 0);
    drain();
  endtask

  bit done = 0;

  initial begin
    testReset();
    testBelow();
    testRamp();
    testTopCutoff();
    testCfgLatency();
    testOneSided();
    testBackpressure();
    testThroughput();
    check("queue empty at end", expQ.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule